// File: doc/BRIEF.md
# Instruction Decode and Arithmetic Slice

This block is the purely combinational heart of a one-instruction-per-cycle integer core. It takes a 32-bit instruction word and two 32-bit operands and, in the same cycle, produces two things. The first is the control word that steers the rest of the datapath: where the destination register comes from, whether the second operand is an immediate, where the write-back data comes from, and the enables for register write, memory read, memory write and branch. The second is the arithmetic result of the selected operation, with a flag that is high when that result is zero.

Decoding happens in two levels. A primary decoder reads the 6-bit opcode in bits 31:26 and emits a 2-bit operation class. A secondary decoder combines that class with the 6-bit function code in bits 5:0 to form a 4-bit operation select. The operand path carries that select into a 32-bit arithmetic unit.

The register file, memories, program counter, sign extension and immediate muxing all stay outside the block. The second operand arrives already selected. The control outputs are plain level signals that are valid whenever the inputs are stable. The block holds no state, so it has no stream handshake and no back-pressure.

Top module: `instr_exec_slice`

## Requirements
- R1: Opcode 000000 (register form) drives dst_from_rd=1, opb_is_imm=0, wb_from_mem=0, rf_wr_en=1, mem_rd_en=0, mem_wr_en=0, branch_en=0 and alu_class=10.
- R2: Opcode 100011 (load) drives dst_from_rd=0, opb_is_imm=1, wb_from_mem=1, rf_wr_en=1, mem_rd_en=1, mem_wr_en=0, branch_en=0 and alu_class=00.
- R3: Opcode 101011 (store) drives opb_is_imm=1, rf_wr_en=0, mem_rd_en=0, mem_wr_en=1, branch_en=0 and alu_class=00. Its don't-care outputs dst_from_rd and wb_from_mem are driven to 0.
- R4: Opcode 000100 (branch on equal) drives opb_is_imm=0, rf_wr_en=0, mem_rd_en=0, mem_wr_en=0, branch_en=1 and alu_class=01. dst_from_rd and wb_from_mem are driven to 0.
- R5: Opcode 001000 (add immediate) drives dst_from_rd=0, opb_is_imm=1, wb_from_mem=0, rf_wr_en=1, mem_rd_en=0, mem_wr_en=0, branch_en=0 and alu_class=00.
- R6: Any other opcode drives every control output to 0 and alu_class to 00, so the unit adds and no state changes.
- R7: With alu_class 00 the select is 0010 (add), and with 01 it is 0110 (subtract). The function code in bits 5:0 has no effect in either case, and class 11 also gives add.
- R8: With alu_class 10 the function code maps to a select as follows: 100000 gives 0010, 100010 gives 0110, 100100 gives 0000, 100101 gives 0001, 100111 gives 1100 and 101010 gives 0111. Every other function code gives 0010.
- R9: The select codes 0010, 0110, 0000, 0001 and 1100 make alu_result equal to A+B, A-B, A AND B, A OR B and NOT(A OR B). Addition and subtraction wrap modulo 2^32.
- R10: Select 0111 makes alu_result 1 when A is less than B as two's-complement signed numbers, and 0 otherwise. For example, A=0xFFFFFFFF with B=1 gives 1.
- R11: result_zero is 1 exactly when all 32 bits of alu_result are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 32 | Instruction word; opcode in bits 31:26, function code in bits 5:0 |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, already selected |
| dst_from_rd | output | 1 | Destination register taken from the rd field |
| opb_is_imm | output | 1 | Second operand should come from the immediate |
| wb_from_mem | output | 1 | Write-back data comes from memory |
| rf_wr_en | output | 1 | Register file write enable |
| mem_rd_en | output | 1 | Data memory read enable |
| mem_wr_en | output | 1 | Data memory write enable |
| branch_en | output | 1 | Conditional branch instruction |
| alu_class | output | 2 | Operation class passed to the secondary decoder |
| alu_sel | output | 4 | Operation select applied to the arithmetic unit |
| alu_result | output | 32 | Arithmetic result |
| result_zero | output | 1 | alu_result is all zeros |

## Verification
The block holds no state, so a wrong decode entry or a broken arithmetic path shows at the ports as soon as the inputs settle, in the same cycle the instruction is applied. A fault in the primary decoder appears on the control pins and on alu_class. It also appears on alu_sel, because the class feeds the secondary decoder. A fault in the secondary decoder appears on alu_sel alone, or on alu_result when operand patterns expose the difference between two operations. The sweep covers every opcode crossed with every function code. The operand mix includes equal pairs, sign-boundary values and pseudo-random words, so zero detection, signed comparison and wrap-around are all exercised.

// File: rtl/instr_slice_pkg.sv
package instr_slice_pkg;

  localparam int OPC_W = 6;
  localparam int FN_W  = 6;
  localparam int SEL_W = 4;
  localparam int CLS_W = 2;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BREQ  = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'b001000;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_NOR = 6'b100111;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

  localparam logic [SEL_W-1:0] SEL_AND = 4'b0000;
  localparam logic [SEL_W-1:0] SEL_OR  = 4'b0001;
  localparam logic [SEL_W-1:0] SEL_ADD = 4'b0010;
  localparam logic [SEL_W-1:0] SEL_SUB = 4'b0110;
  localparam logic [SEL_W-1:0] SEL_SLT = 4'b0111;
  localparam logic [SEL_W-1:0] SEL_NOR = 4'b1100;

  localparam logic [CLS_W-1:0] CLS_ADD   = 2'b00;
  localparam logic [CLS_W-1:0] CLS_SUB   = 2'b01;
  localparam logic [CLS_W-1:0] CLS_FUNCT = 2'b10;

  typedef struct packed {
    logic             dst_rd;
    logic             opb_imm;
    logic             wb_mem;
    logic             rf_we;
    logic             mem_re;
    logic             mem_we;
    logic             br_en;
    logic [CLS_W-1:0] cls;
  } ctrl_t;

endpackage

// File: rtl/primary_decoder.sv
module primary_decoder
  import instr_slice_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output ctrl_t            ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    unique case (opcode_i)
      OPC_REG: begin
        ctrl_o.dst_rd = 1'b1;
        ctrl_o.rf_we  = 1'b1;
        ctrl_o.cls    = CLS_FUNCT;
      end
      OPC_LOAD: begin
        ctrl_o.opb_imm = 1'b1;
        ctrl_o.wb_mem  = 1'b1;
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.mem_re  = 1'b1;
        ctrl_o.cls     = CLS_ADD;
      end
      OPC_STORE: begin
        ctrl_o.opb_imm = 1'b1;
        ctrl_o.mem_we  = 1'b1;
        ctrl_o.cls     = CLS_ADD;
      end
      OPC_BREQ: begin
        ctrl_o.br_en = 1'b1;
        ctrl_o.cls   = CLS_SUB;
      end
      OPC_ADDI: begin
        ctrl_o.opb_imm = 1'b1;
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.cls     = CLS_ADD;
      end
      default: ctrl_o = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown(opcode_i)) begin
      // R6: at most one memory or branch side effect per instruction
      a_r6_single_effect: assert ($onehot0({ctrl_o.mem_re, ctrl_o.mem_we, ctrl_o.br_en}));
      // R3: a store never writes the register file
      a_r3_store_no_rf: assert (!ctrl_o.mem_we || !ctrl_o.rf_we);
      // R2: memory write-back only happens alongside a memory read
      a_r2_wb_needs_read: assert (!ctrl_o.wb_mem || ctrl_o.mem_re);
    end
  end

endmodule

// File: rtl/op_select_decoder.sv
module op_select_decoder
  import instr_slice_pkg::*;
(
  input  logic [CLS_W-1:0] cls_i,
  input  logic [FN_W-1:0]  funct_i,
  output logic [SEL_W-1:0] sel_o
);

  logic [SEL_W-1:0] funct_sel;

  always_comb begin
    unique case (funct_i)
      FN_ADD:  funct_sel = SEL_ADD;
      FN_SUB:  funct_sel = SEL_SUB;
      FN_AND:  funct_sel = SEL_AND;
      FN_OR:   funct_sel = SEL_OR;
      FN_NOR:  funct_sel = SEL_NOR;
      FN_SLT:  funct_sel = SEL_SLT;
      default: funct_sel = SEL_ADD;
    endcase
  end

  always_comb begin
    unique case (cls_i)
      CLS_SUB:   sel_o = SEL_SUB;
      CLS_FUNCT: sel_o = funct_sel;
      default:   sel_o = SEL_ADD;
    endcase
  end

  always_comb begin
    if (!$isunknown({cls_i, funct_i})) begin
      // R8: only the six defined select codes ever leave the decoder
      a_r8_legal_sel: assert (sel_o inside {SEL_AND, SEL_OR, SEL_ADD, SEL_SUB, SEL_SLT, SEL_NOR});
      // R7: without the function class only add or subtract is chosen
      a_r7_fixed_class: assert (cls_i == CLS_FUNCT || sel_o inside {SEL_ADD, SEL_SUB});
    end
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import instr_slice_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [DATA_W-1:0] res_o,
  output logic              zero_o
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] and_v, or_v, nor_v;
  logic [DATA_W-1:0] b_eff, sum_v;
  logic              do_sub, ovf, lt_signed;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign and_v[i] = a_i[i] & b_i[i];
    assign or_v[i]  = a_i[i] | b_i[i];
    assign nor_v[i] = ~or_v[i];
  end

  assign do_sub    = (sel_i == SEL_SUB) || (sel_i == SEL_SLT);
  assign b_eff     = do_sub ? ~b_i : b_i;
  assign sum_v     = a_i + b_eff + {{(DATA_W-1){1'b0}}, do_sub};
  assign ovf       = (a_i[MSB] ^ b_i[MSB]) & (a_i[MSB] ^ sum_v[MSB]);
  assign lt_signed = sum_v[MSB] ^ ovf;

  always_comb begin
    unique case (sel_i)
      SEL_AND: res_o = and_v;
      SEL_OR:  res_o = or_v;
      SEL_NOR: res_o = nor_v;
      SEL_SLT: res_o = {{(DATA_W-1){1'b0}}, lt_signed};
      default: res_o = sum_v;
    endcase
  end

  assign zero_o = ~|res_o;

  always_comb begin
    if (!$isunknown({a_i, b_i, sel_i})) begin
      // R11: subtracting equal operands must raise the zero flag
      a_r11_equal_sub_zero: assert (!(sel_i == SEL_SUB && a_i == b_i) || zero_o);
      // R10: a comparison yields only 0 or 1
      a_r10_slt_bool: assert (sel_i != SEL_SLT || res_o[DATA_W-1:1] == '0);
      // R10: equal operands are never less than each other
      a_r10_slt_equal: assert (!(sel_i == SEL_SLT && a_i == b_i) || zero_o);
    end
  end

endmodule

// File: rtl/instr_exec_slice.sv
module instr_exec_slice
  import instr_slice_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 32
) (
  input  logic [INSTR_W-1:0] instr_word,
  input  logic [DATA_W-1:0]  opnd_a,
  input  logic [DATA_W-1:0]  opnd_b,
  output logic               dst_from_rd,
  output logic               opb_is_imm,
  output logic               wb_from_mem,
  output logic               rf_wr_en,
  output logic               mem_rd_en,
  output logic               mem_wr_en,
  output logic               branch_en,
  output logic [1:0]         alu_class,
  output logic [3:0]         alu_sel,
  output logic [DATA_W-1:0]  alu_result,
  output logic               result_zero
);

  localparam int OPC_LSB = INSTR_W - OPC_W;

  ctrl_t            ctrl;
  logic [SEL_W-1:0] sel;

  primary_decoder u_pdec (
    .opcode_i (instr_word[INSTR_W-1:OPC_LSB]),
    .ctrl_o   (ctrl)
  );

  op_select_decoder u_sdec (
    .cls_i   (ctrl.cls),
    .funct_i (instr_word[FN_W-1:0]),
    .sel_o   (sel)
  );

  int_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i    (opnd_a),
    .b_i    (opnd_b),
    .sel_i  (sel),
    .res_o  (alu_result),
    .zero_o (result_zero)
  );

  assign dst_from_rd = ctrl.dst_rd;
  assign opb_is_imm  = ctrl.opb_imm;
  assign wb_from_mem = ctrl.wb_mem;
  assign rf_wr_en    = ctrl.rf_we;
  assign mem_rd_en   = ctrl.mem_re;
  assign mem_wr_en   = ctrl.mem_we;
  assign branch_en   = ctrl.br_en;
  assign alu_class   = ctrl.cls;
  assign alu_sel     = sel;

  always_comb begin
    if (!$isunknown(instr_word)) begin
      // R4: a branch always compares by subtraction
      a_r4_branch_subtracts: assert (!branch_en || alu_sel == SEL_SUB);
      // R2: memory accesses compute their address by addition
      a_r2_mem_addr_add: assert (!(mem_rd_en || mem_wr_en) || alu_sel == SEL_ADD);
    end
  end

endmodule

// File: tb/sim_instr_exec_slice.sv
`timescale 1ns/1ps
module sim_instr_exec_slice;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] instr_word, opnd_a, opnd_b, alu_result;
  logic dst_from_rd, opb_is_imm, wb_from_mem, rf_wr_en, mem_rd_en, mem_wr_en, branch_en;
  logic [1:0] alu_class;
  logic [3:0] alu_sel;
  logic result_zero;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  instr_exec_slice u0 (
    .instr_word(instr_word), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .dst_from_rd(dst_from_rd), .opb_is_imm(opb_is_imm), .wb_from_mem(wb_from_mem),
    .rf_wr_en(rf_wr_en), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .branch_en(branch_en), .alu_class(alu_class), .alu_sel(alu_sel),
    .alu_result(alu_result), .result_zero(result_zero)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h (instr=%h a=%h b=%h)",
               tag, what, act, exp, instr_word, opnd_a, opnd_b);
    end
  endtask

  // {dst, imm, wb, rf_we, mem_re, mem_we, br, class[1:0]}
  function automatic logic [8:0] ref_ctrl(logic [5:0] op);
    case (op)
      6'b000000: return 9'b1_0_0_1_0_0_0_10;
      6'b100011: return 9'b0_1_1_1_1_0_0_00;
      6'b101011: return 9'b0_1_0_0_0_1_0_00;
      6'b000100: return 9'b0_0_0_0_0_0_1_01;
      6'b001000: return 9'b0_1_0_1_0_0_0_00;
      default:   return 9'b0;
    endcase
  endfunction

  function automatic string ctrl_tag(logic [5:0] op);
    case (op)
      6'b000000: return "R1";
      6'b100011: return "R2";
      6'b101011: return "R3";
      6'b000100: return "R4";
      6'b001000: return "R5";
      default:   return "R6";
    endcase
  endfunction

  function automatic logic [3:0] ref_sel(logic [1:0] cls, logic [5:0] fn);
    if (cls == 2'b01) return 4'b0110;
    if (cls != 2'b10) return 4'b0010;
    case (fn)
      6'b100000: return 4'b0010;
      6'b100010: return 4'b0110;
      6'b100100: return 4'b0000;
      6'b100101: return 4'b0001;
      6'b100111: return 4'b1100;
      6'b101010: return 4'b0111;
      default:   return 4'b0010;
    endcase
  endfunction

  function automatic logic [31:0] ref_res(logic [3:0] sel, logic [31:0] a, logic [31:0] b);
    case (sel)
      4'b0000: return a & b;
      4'b0001: return a | b;
      4'b0110: return a - b;
      4'b0111: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'b1100: return ~(a | b);
      default: return a + b;
    endcase
  endfunction

  function automatic logic [31:0] step(logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic apply(logic [31:0] iw, logic [31:0] a, logic [31:0] b);
    logic [8:0]  ec;
    logic [3:0]  es;
    logic [31:0] er;
    @(posedge clk);
    instr_word = iw; opnd_a = a; opnd_b = b;
    @(negedge clk);
    ec = ref_ctrl(iw[31:26]);
    es = ref_sel(ec[1:0], iw[5:0]);
    er = ref_res(es, a, b);
    chk(ctrl_tag(iw[31:26]), "control",
        {55'd0, dst_from_rd, opb_is_imm, wb_from_mem, rf_wr_en, mem_rd_en,
         mem_wr_en, branch_en, alu_class}, {55'd0, ec});
    chk((ec[1:0] == 2'b10) ? "R8" : "R7", "select", {60'd0, alu_sel}, {60'd0, es});
    chk((es == 4'b0111) ? "R10" : "R9", "result", {32'd0, alu_result}, {32'd0, er});
    chk("R11", "zero", {63'd0, result_zero}, {63'd0, (er == 32'd0)});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    logic [31:0] corner [5];
    corner[0] = 32'h0; corner[1] = 32'h1; corner[2] = 32'hFFFFFFFF;
    corner[3] = 32'h80000000; corner[4] = 32'h7FFFFFFF;
    instr_word = '0; opnd_a = '0; opnd_b = '0;
    s = 32'h1234ABCD;

    // Initial state with all-zero inputs: register-form add of zeros
    apply(32'h0000_0020, 32'h0, 32'h0);

    // Example vectors (R9, R10, R11, R2, R4)
    apply(32'h0000_0024, 32'hFFFFFFFF, 32'h1);
    apply(32'h0000_0025, 32'hFFFFFFFF, 32'h1);
    apply(32'h0000_0020, 32'hFFFFFFFF, 32'h1);
    apply(32'h0000_0022, 32'hFFFFFFFF, 32'h1);
    apply(32'h0000_002A, 32'hFFFFFFFF, 32'h1);
    apply(32'h0000_0027, 32'hFFFFFFFF, 32'h1);
    apply(32'h2000_0004, 32'hFFFFFFFB, 32'h4);
    apply(32'h8C00_0020, 32'h000000FF, 32'h20);
    apply(32'hAC00_0064, 32'h000000FF, 32'h64);
    apply(32'h1000_0025, 32'h000000FF, 32'h25);

    // Signed comparison across the sign boundary (R10)
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        apply(32'h0000_002A, corner[i], corner[j]);

    // Full sweep: every opcode with every function code (R1..R11)
    for (int op = 0; op < 64; op++) begin
      for (int fn = 0; fn < 64; fn++) begin
        logic [31:0] a, b;
        s = step(s); a = s;
        s = step(s); b = s;
        case (fn % 4)
          1: b = a;
          2: b = corner[fn % 5];
          3: a = corner[(fn / 4) % 5];
          default: ;
        endcase
        apply({op[5:0], s[25:6], fn[5:0]}, a, b);
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule